// File: doc/BRIEF.md
# Single-Precision Multiply Exception Flag Unit

This unit takes two IEEE-754 single-precision operands and reports which IEEE exceptions their product would raise. It does not deliver the product itself. The result is a 32-bit integer flag vector that a register file can store directly. Denormal operands are treated as zero, in flush-to-zero fashion, and this is reported with its own flag. A product that would land in the denormal range is reported as flushed with a second flag. Rounding for the overflow and inexact decisions follows a 2-bit rounding-mode input.

The unit is a three-stage pipeline and accepts a new operation on every clock. The first stage classifies the operands and settles the special cases. The second stage forms the 24x24 significand product. The third stage normalises and rounds the product and assembles the flags. A guard bit travels with each operation, and the write-enable for the result is raised only when that bit is 1.

Top module: `fp32_mul_exc`

## Requirements
- R1: The flag vector is 32 bits wide with bits 31..7 always zero. Bit 6 = output flushed to zero (OFZ), bit 5 = input flushed to zero (IFZ), bit 4 = invalid (INV), bit 3 = overflow (OVF), bit 2 = underflow (UNF), bit 1 = inexact (INX), bit 0 = divide-by-zero (DBZ). DBZ is never set.
- R2: `valid_o` is high exactly 3 clock cycles after an `issue_i` pulse. Back-to-back operations, one per cycle, each produce their own result in order.
- R3: `wr_en_o` equals `valid_o` ANDed with the `guard_i` value issued with that operation. A result with guard 0 still appears on `flags_o`, but with `wr_en_o` low.
- R4: An operand with exponent field 0 and a nonzero fraction is replaced by zero and sets IFZ. For example, 3.0 x 0x00400000 gives 0x20.
- R5: If either operand is a NaN, the result is INV alone (0x10), whatever the other operand is.
- R6: Infinity times zero gives INV. If the zero came from a flushed denormal, IFZ is also set (0x30). Infinity times a nonzero number or infinity, of either sign, gives 0.
- R7: If the rounded product exceeds the largest finite value, the result is OVF and INX (0x0A). The rounding mode is encoded as 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. For example, 0x7F7FFFFE x 0x3F800001 gives 0x0A under modes 0 and 2 and gives 0x02 under modes 1 and 3.
- R8: A product below 2^-126 but at or above 2^-149 (the lowest denormal binade) gives OFZ, UNF and INX (0x46). For example, 0.5 x 0x00800000 and 0x00800000 x 0x34000000 both give this.
- R9: A product below 2^-149 gives UNF and INX only (0x06). For example, 0x00800000 squared and 0x00800000 x 0x33800000 both give this.
- R10: An in-range product gives INX alone (0x02) when it is inexact and 0 when it is exact.
- R11: While `rst_n` is low at a clock edge, the following cycle shows `valid_o`, `wr_en_o` and `flags_o` all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Starts an operation this cycle |
| op_a_i | input | 32 | First single-precision operand |
| op_b_i | input | 32 | Second single-precision operand |
| rmode_i | input | 2 | Rounding mode (0 nearest-even, 1 zero, 2 +inf, 3 -inf) |
| guard_i | input | 1 | Guard LSB; 1 permits the result write |
| valid_o | output | 1 | Result present, 3 cycles after issue |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 32 | Exception flag vector |

## Verification
A wrong valid or guard bit in one pipeline stage shows up at the ports exactly three cycles after the affected issue: `valid_o` or `wr_en_o` is set for the wrong slot, or a burst loses or duplicates a result. A mis-set special-case flag or a wrong exponent carried between stages shows up in that same cycle as a wrong `flags_o` code. Exponent errors are exposed by operand pairs that sit exactly on the 2^-149 and overflow boundaries. Rounding-mode mistakes show up only on products that lie one rounding step below overflow, so each mode is driven there with both signs.

// File: rtl/fp32_mul_exc_pkg.sv
// Shared widths, flag positions and types for the multiply exception unit.
// Assumes IEEE-754 binary32 layout: sign, biased exponent, fraction.
package fp32_mul_exc_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int REST_W  = PROD_W - SIG_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int SE_W    = EXP_W + 3;
    localparam int FLAG_N  = 7;

    // Flag bit positions in the result vector
    localparam int FB_DBZ = 0;
    localparam int FB_INX = 1;
    localparam int FB_UNF = 2;
    localparam int FB_OVF = 3;
    localparam int FB_INV = 4;
    localparam int FB_IFZ = 5;
    localparam int FB_OFZ = 6;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_POS  = 2'd2,
        RND_NEG  = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic is_zero;   // true zero or flushed denormal
        logic is_den;    // denormal that was flushed
        logic is_inf;
        logic is_nan;
    } op_class_t;
endpackage

// File: rtl/fmx_classify.sv
// Operand classifier: splits a binary32 word into exponent and significand
// with the hidden bit, and tags zero/denormal/infinity/NaN.
// Assumes flush-to-zero: a denormal is reported as zero as well.
module fmx_classify
    import fp32_mul_exc_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    output op_class_t         cls,
    output logic [EXP_W-1:0]  expo,
    output logic [SIG_W-1:0]  sig
);
    logic exp_ones, exp_none, frac_any;

    // Field decode and class tagging
    always_comb begin
        expo        = op[WORD_W-2 -: EXP_W];
        sig         = {1'b1, op[FRAC_W-1:0]};
        exp_ones    = &expo;
        exp_none    = ~|expo;
        frac_any    = |op[FRAC_W-1:0];
        cls.is_nan  = exp_ones & frac_any;
        cls.is_inf  = exp_ones & ~frac_any;
        cls.is_den  = exp_none & frac_any;
        cls.is_zero = exp_none;
    end
endmodule

// File: rtl/fmx_special.sv
// Special-operand resolver: decides the flags outright when either operand
// is NaN, infinity or zero (after flushing), so no product is needed.
// Assumes both class inputs come from fmx_classify.
module fmx_special
    import fp32_mul_exc_pkg::*;
(
    input  op_class_t         cls_a,
    input  op_class_t         cls_b,
    output logic              special,
    output logic [FLAG_N-1:0] sflags
);
    logic any_nan, any_inf, any_zero, any_den;

    // Priority resolution of the special cases
    always_comb begin
        any_nan  = cls_a.is_nan  | cls_b.is_nan;
        any_inf  = cls_a.is_inf  | cls_b.is_inf;
        any_zero = cls_a.is_zero | cls_b.is_zero;
        any_den  = cls_a.is_den  | cls_b.is_den;
        sflags   = '0;
        special  = 1'b1;
        if (any_nan) begin
            sflags[FB_INV] = 1'b1;
        end else if (any_inf && any_zero) begin
            sflags[FB_INV] = 1'b1;
            sflags[FB_IFZ] = any_den;
        end else if (any_inf) begin
            sflags = '0;
        end else if (any_zero) begin
            sflags[FB_IFZ] = any_den;
        end else begin
            special = 1'b0;
        end
    end
endmodule

// File: rtl/fmx_round_flags.sv
// Normalise, round and flag: takes the raw significand product and the
// unnormalised exponent and returns the OVF/UNF/INX/OFZ flags.
// Assumes both operands were normal, so the product lies in [1,4).
module fmx_round_flags
    import fp32_mul_exc_pkg::*;
(
    input  logic [PROD_W-1:0]       prod,
    input  logic signed [SE_W-1:0]  exp_sum,
    input  logic                    sign,
    input  logic [1:0]              rmode,
    output logic [FLAG_N-1:0]       rflags
);
    localparam logic signed [SE_W-1:0] E_ZERO    = '0;
    localparam logic signed [SE_W-1:0] E_OFZ_MIN = SE_W'(1 - FRAC_W);
    localparam logic signed [SE_W-1:0] E_OVF     = SE_W'(EXP_MAX);

    logic                   hi, g_bit, s_bit, inexact, up;
    logic [SIG_W-1:0]       mant;
    logic [REST_W-1:0]      rest;
    logic signed [SE_W-1:0] e_n, e_r;

    // Normalisation and rounding decision
    always_comb begin
        hi    = prod[PROD_W-1];
        mant  = hi ? prod[PROD_W-1 -: SIG_W] : prod[PROD_W-2 -: SIG_W];
        rest  = hi ? prod[REST_W-1:0] : {prod[REST_W-2:0], 1'b0};
        e_n   = exp_sum + $signed({{(SE_W-1){1'b0}}, hi});
        g_bit = rest[REST_W-1];
        s_bit = |rest[REST_W-2:0];
        inexact = g_bit | s_bit;
        unique case (rnd_mode_e'(rmode))
            RND_NEAR: up = g_bit & (s_bit | mant[0]);
            RND_ZERO: up = 1'b0;
            RND_POS:  up = ~sign & inexact;
            RND_NEG:  up = sign & inexact;
            default:  up = 1'b0;
        endcase
        e_r = e_n + $signed({{(SE_W-1){1'b0}}, up & (&mant)});
    end

    // Flag assembly from the range of the result
    always_comb begin
        rflags = '0;
        if (e_n <= E_ZERO) begin
            rflags[FB_UNF] = 1'b1;
            rflags[FB_INX] = 1'b1;
            rflags[FB_OFZ] = (e_n >= E_OFZ_MIN);
        end else if (e_r >= E_OVF) begin
            rflags[FB_OVF] = 1'b1;
            rflags[FB_INX] = 1'b1;
        end else begin
            rflags[FB_INX] = inexact;
        end
    end
endmodule

// File: rtl/fp32_mul_exc.sv
// Three-stage pipelined single-precision multiply exception unit.
// Stage 1 classifies and resolves special cases, stage 2 multiplies the
// significands, stage 3 rounds and registers the flag vector.
// Assumes one operation per cycle at most; synchronous active-low reset.
module fp32_mul_exc
    import fp32_mul_exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [WORD_W-1:0] op_a_i,
    input  logic [WORD_W-1:0] op_b_i,
    input  logic [1:0]        rmode_i,
    input  logic              guard_i,
    output logic              valid_o,
    output logic              wr_en_o,
    output logic [WORD_W-1:0] flags_o
);
    op_class_t              cls_a, cls_b;
    logic [EXP_W-1:0]       exp_a, exp_b;
    logic [SIG_W-1:0]       sig_a, sig_b;
    logic                   spec_c;
    logic [FLAG_N-1:0]      sflags_c, rflags_c;
    logic signed [SE_W-1:0] exp_sum_c;

    logic                   s1_valid, s1_guard, s1_sign, s1_special;
    logic [1:0]             s1_rm;
    logic [FLAG_N-1:0]      s1_sflags;
    logic signed [SE_W-1:0] s1_exp;
    logic [SIG_W-1:0]       s1_siga, s1_sigb;

    logic                   s2_valid, s2_guard, s2_sign, s2_special;
    logic [1:0]             s2_rm;
    logic [FLAG_N-1:0]      s2_sflags;
    logic signed [SE_W-1:0] s2_exp;
    logic [PROD_W-1:0]      s2_prod;

    fmx_classify u_cls_a (.op(op_a_i), .cls(cls_a), .expo(exp_a), .sig(sig_a));
    fmx_classify u_cls_b (.op(op_b_i), .cls(cls_b), .expo(exp_b), .sig(sig_b));

    fmx_special u_spec (
        .cls_a(cls_a), .cls_b(cls_b), .special(spec_c), .sflags(sflags_c)
    );

    // Unnormalised biased exponent of the product
    assign exp_sum_c = $signed({{(SE_W-EXP_W){1'b0}}, exp_a})
                     + $signed({{(SE_W-EXP_W){1'b0}}, exp_b})
                     - $signed(SE_W'(BIAS));

    // Stage 1: capture decoded operands and special-case result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s1_guard   <= 1'b0;
            s1_sign    <= 1'b0;
            s1_special <= 1'b0;
            s1_rm      <= '0;
            s1_sflags  <= '0;
            s1_exp     <= '0;
            s1_siga    <= '0;
            s1_sigb    <= '0;
        end else begin
            s1_valid   <= issue_i;
            s1_guard   <= guard_i;
            s1_sign    <= op_a_i[WORD_W-1] ^ op_b_i[WORD_W-1];
            s1_special <= spec_c;
            s1_rm      <= rmode_i;
            s1_sflags  <= sflags_c;
            s1_exp     <= exp_sum_c;
            s1_siga    <= sig_a;
            s1_sigb    <= sig_b;
        end
    end

    // Stage 2: significand product
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid   <= 1'b0;
            s2_guard   <= 1'b0;
            s2_sign    <= 1'b0;
            s2_special <= 1'b0;
            s2_rm      <= '0;
            s2_sflags  <= '0;
            s2_exp     <= '0;
            s2_prod    <= '0;
        end else begin
            s2_valid   <= s1_valid;
            s2_guard   <= s1_guard;
            s2_sign    <= s1_sign;
            s2_special <= s1_special;
            s2_rm      <= s1_rm;
            s2_sflags  <= s1_sflags;
            s2_exp     <= s1_exp;
            s2_prod    <= s1_siga * s1_sigb;
        end
    end

    fmx_round_flags u_rnd (
        .prod(s2_prod), .exp_sum(s2_exp), .sign(s2_sign),
        .rmode(s2_rm), .rflags(rflags_c)
    );

    // Stage 3: select and register the final flag vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            wr_en_o <= 1'b0;
            flags_o <= '0;
        end else begin
            valid_o <= s2_valid;
            wr_en_o <= s2_valid & s2_guard;
            flags_o <= {{(WORD_W-FLAG_N){1'b0}},
                        (s2_special ? s2_sflags : rflags_c)};
        end
    end
endmodule

// File: rtl/fp32_mul_exc_chk.sv
// Property checker for fp32_mul_exc, attached by bind below.
// Assumes the unit's three-cycle latency and flag layout.
module fp32_mul_exc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_i,
    input logic        guard_i,
    input logic        valid_o,
    input logic        wr_en_o,
    input logic [31:0] flags_o
);
    logic [1:0] warm_cnt;
    logic       warm;

    // Count clean cycles since reset so $past never reaches into reset
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end
    assign warm = (warm_cnt == 2'd3);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (valid_o == $past(issue_i, 3)));

    assert_guard_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (wr_en_o == $past(issue_i & guard_i, 3)));

    assert_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (flags_o[31:7] == '0 && !flags_o[0]));

    assert_nan_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && flags_o[4]) |-> (flags_o[3:1] == '0 && !flags_o[6]));

    assert_overflow_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && flags_o[3]) |-> (flags_o[1] && !flags_o[2]));

    assert_flush_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && flags_o[6]) |-> (flags_o[2] && flags_o[1]));

    assert_reset_clear_R11: assert property (@(posedge clk)
        (!rst_n) |=> (!valid_o && !wr_en_o && flags_o == '0));
endmodule

bind fp32_mul_exc fp32_mul_exc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .guard_i(guard_i),
    .valid_o(valid_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
);

// File: tb/sim_fp32_mul_exc.sv
// Directed bench: each task loads a burst of operations with expected
// flags and runs them back to back through the pipeline.
module sim_fp32_mul_exc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic [1:0]  rmode_i = '0;
    logic        guard_i = 1'b0;
    logic        valid_o, wr_en_o;
    logic [31:0] flags_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] qa [8];
    logic [31:0] qb [8];
    logic [1:0]  qrm [8];
    logic        qg [8];
    logic [31:0] qexp [8];
    string       qtag [8];

    always #4 clk = ~clk;

    fp32_mul_exc u0 (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_a_i(op_a_i),
        .op_b_i(op_b_i), .rmode_i(rmode_i), .guard_i(guard_i),
        .valid_o(valid_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic put(int i, logic [31:0] a, logic [31:0] b, logic [1:0] rm,
                       logic g, logic [31:0] e, string tag);
        qa[i] = a; qb[i] = b; qrm[i] = rm; qg[i] = g; qexp[i] = e; qtag[i] = tag;
    endtask

    // Issue n ops on consecutive cycles; result of op j is checked 3 cycles on
    task automatic run(int n);
        for (int i = 0; i < n + 4; i++) begin
            @(negedge clk);
            if (i >= 3 && i < n + 3) begin
                check({qtag[i-3], " flags"}, flags_o, qexp[i-3]);
                check({qtag[i-3], " valid R2"}, {31'b0, valid_o}, 32'd1);
                check({qtag[i-3], " wr_en R3"}, {31'b0, wr_en_o}, {31'b0, qg[i-3]});
            end
            if (i == n + 3)
                check("R2 valid drops after burst", {31'b0, valid_o}, 32'd0);
            if (i < n) begin
                issue_i = 1'b1; op_a_i = qa[i]; op_b_i = qb[i];
                rmode_i = qrm[i]; guard_i = qg[i];
            end else begin
                issue_i = 1'b0; guard_i = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R11 valid in reset", {31'b0, valid_o}, 32'd0);
        check("R11 wr_en in reset", {31'b0, wr_en_o}, 32'd0);
        check("R11 flags in reset", flags_o, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 valid idle", {31'b0, valid_o}, 32'd0);
    endtask

    task automatic t_exact();
        put(0, 32'hC0400000, 32'h3F800000, 2'd0, 1'b1, 32'h00, "R10 -3*1");
        put(1, 32'h40400000, 32'hC0400000, 2'd0, 1'b1, 32'h00, "R10 3*-3");
        put(2, 32'h3F800001, 32'h3F800001, 2'd0, 1'b1, 32'h02, "R10 inexact");
        run(3);
    endtask

    task automatic t_guard();
        put(0, 32'h40400000, 32'h00800000, 2'd0, 1'b0, 32'h00, "R3 guard0");
        put(1, 32'h40400000, 32'h00800000, 2'd0, 1'b1, 32'h00, "R3 guard1");
        run(2);
    endtask

    task automatic t_denorm_in();
        put(0, 32'h40400000, 32'h00400000, 2'd0, 1'b1, 32'h20, "R4 3*den");
        put(1, 32'h00400000, 32'h00400000, 2'd1, 1'b1, 32'h20, "R4 den*den");
        run(2);
    endtask

    task automatic t_nan();
        put(0, 32'h7FC00000, 32'h3F800000, 2'd0, 1'b1, 32'h10, "R5 nan*1");
        put(1, 32'h7F800001, 32'h00400000, 2'd0, 1'b1, 32'h10, "R5 nan*den");
        put(2, 32'h7F7FFFFF, 32'hFFC00000, 2'd0, 1'b1, 32'h10, "R5 max*nan");
        run(3);
    endtask

    task automatic t_inf();
        put(0, 32'h7F800000, 32'h00000000, 2'd0, 1'b1, 32'h10, "R6 inf*0");
        put(1, 32'h7F800000, 32'h00400000, 2'd0, 1'b1, 32'h30, "R6 inf*den");
        put(2, 32'h7F800000, 32'hFF800000, 2'd0, 1'b1, 32'h00, "R6 inf*-inf");
        put(3, 32'hFF800000, 32'h40400000, 2'd0, 1'b1, 32'h00, "R6 -inf*3");
        run(4);
    endtask

    task automatic t_overflow();
        put(0, 32'h7F7FFFFF, 32'h7F7FFFFF, 2'd0, 1'b1, 32'h0A, "R7 max^2");
        put(1, 32'h7F7FFFFE, 32'h3F800001, 2'd0, 1'b1, 32'h0A, "R7 edge near");
        put(2, 32'h7F7FFFFE, 32'h3F800001, 2'd1, 1'b1, 32'h02, "R7 edge zero");
        put(3, 32'h7F7FFFFE, 32'h3F800001, 2'd2, 1'b1, 32'h0A, "R7 edge pos");
        put(4, 32'h7F7FFFFE, 32'h3F800001, 2'd3, 1'b1, 32'h02, "R7 edge neg");
        put(5, 32'hFF7FFFFE, 32'h3F800001, 2'd2, 1'b1, 32'h02, "R7 -edge pos");
        put(6, 32'hFF7FFFFE, 32'h3F800001, 2'd3, 1'b1, 32'h0A, "R7 -edge neg");
        run(7);
    endtask

    task automatic t_tiny();
        put(0, 32'h3F000000, 32'h00800000, 2'd0, 1'b1, 32'h46, "R8 half*min");
        put(1, 32'h00800000, 32'h34000000, 2'd0, 1'b1, 32'h46, "R8 2^-149");
        put(2, 32'h00800000, 32'h33800000, 2'd0, 1'b1, 32'h06, "R9 2^-150");
        put(3, 32'h00800000, 32'h00800000, 2'd2, 1'b1, 32'h06, "R9 min^2");
        put(4, 32'h00C00000, 32'h80800000, 2'd0, 1'b1, 32'h06, "R9 mixed sign");
        put(5, 32'h40400000, 32'h40000000, 2'd0, 1'b0, 32'h00, "R1 plain");
        run(6);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_exact();
        t_guard();
        t_denorm_in();
        t_nan();
        t_inf();
        t_overflow();
        t_tiny();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule